// File: doc/BRIEF.md
# Live CPU Clock Source Selector

This block drives the processor clock from one of three candidates: a free-running fast crystal clock (nominally 20 MHz), the same clock halved by a toggle stage (10 MHz), or a second, slower crystal clock (nominally 14.31818 MHz). Software picks the candidate through a two-bit field in one register. The host reaches that register over a small I/O bus with an 8-bit address, 8-bit write and read data, and single-cycle read and write strobes.

A new choice takes effect while the system runs, with no reset. The bus-side controller first withdraws the request of the current source and waits until that source reports its gate closed. Only then does it raise the request of the new one. Each source owns a gate enable. The enable passes through a short synchronizer that updates only while its own clock is low. As a result, the output carries only whole phases of a source, and it rests low during the hand-over. A one-hot status output names the source that currently drives the output. It reads all-zero while a hand-over is in progress.

Top module: `cpu_clk_selector`

## Requirements
- R1: While `rst` is high, the select field clears to 00 (it reads back as 8'h00). After `rst` falls, the full-rate fast clock becomes the active source, and `src_on` reads 3'b001.
- R2: A write strobe at address `REG_ADDR` (default 8'h7B) stores data bits 3:2 as the select field. A read strobe at that address returns the field in bits 3:2 and zeros in every other bit, on `io_rdata` one bus clock later.
- R3: A write to any other address leaves the select field and the output clock unchanged. A read of any other address returns 8'h00.
- R4: Select code 00 gives the fast clock at full rate (50 ns period by default). Code 01 gives the fast clock divided by two (100 ns). Codes 10 and 11 give the slow clock (69.842 ns).
- R5: At most one source gate is ever open. `src_on` is one-hot with bit 0 for fast, bit 1 for halved and bit 2 for slow, and it never has more than one bit set.
- R6: A change of source is break-before-make. `src_on` passes through 3'b000 between the old and the new value. The output stays low for a gap longer than 55 ns, which is longer than any single low phase of any source.
- R7: No high or low phase of `cpu_clk` is shorter than the shortest phase of any source (25 ns by default).
- R8: Writing a code that maps to the source already active (including 10 versus 11) does not interrupt the output. `src_on` stays at its value, and no low phase exceeds that source's own low phase.
- R9: When several codes are written while a hand-over is still in progress, the output settles on the source of the last code written, with no reset needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Host bus and control clock |
| rst | input | 1 | Synchronous active-high reset, bus clock domain |
| clk_fast | input | 1 | Fast free-running source clock |
| clk_slow | input | 1 | Slow free-running source clock |
| io_addr | input | 8 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | Write strobe, one bus clock |
| io_rd | input | 1 | Read strobe, one bus clock |
| io_rdata | output | 8 | Registered read data |
| cpu_clk | output | 1 | Selected processor clock |
| src_on | output | 3 | One-hot active source, zero during a hand-over |

## Verification
The assertions check the following on every bus clock: the register only changes on a matching write, at most one gate enable is open, the status never jumps straight from one source to another, and a new request is issued only after the status has shown every gate closed. Other properties depend on real time and cannot be seen edge by edge. These are the output period for each code, the length of the low gap during a hand-over, the shortest phase ever seen on the output, and the absence of any hiccup when the same source is rewritten. The bench scenarios measure them with timestamps on every output edge.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_HALF = 2'd1,
    SRC_SLOW = 2'd2
  } src_e;

  function automatic src_e code_to_src(input logic [1:0] code);
    if (code[1])      return SRC_SLOW;
    else if (code[0]) return SRC_HALF;
    else              return SRC_FAST;
  endfunction

  function automatic logic [NSRC-1:0] src_onehot(input src_e s);
    logic [NSRC-1:0] v;
    v = '0;
    v[s] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/clksel_regs.sv
module clksel_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h7B,
  parameter int SEL_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        sel
);
  localparam int SEL_MSB = SEL_LSB + 1;

  logic hit;
  assign hit = (addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
    end else if (wr && hit) begin
      sel <= wdata[SEL_MSB:SEL_LSB];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (rd && hit) rdata[SEL_MSB:SEL_LSB] <= sel;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> sel == 2'b00);
  a_r2_write_stores: assert property (@(posedge clk) disable iff (rst)
    (wr && hit) |=> sel == $past(wdata[SEL_MSB:SEL_LSB]));
  a_r3_other_ignored: assert property (@(posedge clk) disable iff (rst)
    !(wr && hit) |=> $stable(sel));
endmodule

// File: rtl/clksel_div2.sv
module clksel_div2 #(
  parameter int RST_STAGES = 2
) (
  input  logic clk_fast,
  input  logic rst_bus,
  output logic half_q
);
  logic [RST_STAGES-1:0] rst_sh;

  always_ff @(posedge clk_fast) begin
    rst_sh <= {rst_sh[RST_STAGES-2:0], rst_bus};
  end

  always_ff @(posedge clk_fast) begin
    if (rst_sh[RST_STAGES-1]) half_q <= 1'b0;
    else                      half_q <= ~half_q;
  end
endmodule

// File: rtl/clksel_leg.sv
module clksel_leg #(
  parameter int STAGES = 2
) (
  input  logic clk_upd,
  input  logic upd_ce,
  input  logic clk_src,
  input  logic rst_bus,
  input  logic req,
  output logic en,
  output logic gclk
);
  logic [STAGES-1:0] rst_sh;
  logic [STAGES-1:0] en_sh;

  always_ff @(negedge clk_upd) begin
    rst_sh <= {rst_sh[STAGES-2:0], rst_bus};
  end

  always_ff @(negedge clk_upd) begin
    if (rst_sh[STAGES-1])  en_sh <= '0;
    else if (upd_ce)       en_sh <= {en_sh[STAGES-2:0], req};
  end

  assign en   = en_sh[STAGES-1];
  assign gclk = clk_src & en;
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      sel,
  input  logic [NSRC-1:0] en_raw,
  output logic [NSRC-1:0] req,
  output logic [NSRC-1:0] src_on
);
  typedef enum logic [1:0] {ST_IDLE, ST_DROP, ST_RISE} st_e;

  st_e  state;
  src_e target;
  src_e want;

  assign want = code_to_src(sel);

  for (genvar i = 0; i < NSRC; i++) begin : g_sync
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-2:0], en_raw[i]};
    end
    assign src_on[i] = sh[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_DROP;
      target <= SRC_FAST;
      req    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (want != target) begin
          req   <= '0;
          state <= ST_DROP;
        end
        ST_DROP: if (src_on == '0) begin
          target <= want;
          req    <= src_onehot(want);
          state  <= ST_RISE;
        end
        ST_RISE: if (src_on == src_onehot(target)) state <= ST_IDLE;
        default: state <= ST_DROP;
      endcase
    end
  end

  a_r5_status_onehot0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_on));
  a_r6_no_direct_swap: assert property (@(posedge clk) disable iff (rst)
    (src_on != '0 && $past(src_on) != '0) |-> src_on == $past(src_on));
  a_r6_break_before_make: assert property (@(posedge clk) disable iff (rst)
    (req != '0 && $past(req) == '0) |-> $past(src_on) == '0);
endmodule

// File: rtl/cpu_clk_selector.sv
module cpu_clk_selector
  import clksel_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h7B,
  parameter int SEL_LSB = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_bus,
  input  logic              rst,
  input  logic              clk_fast,
  input  logic              clk_slow,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rdata,
  output logic              cpu_clk,
  output logic [NSRC-1:0]   src_on
);
  logic [1:0]      sel;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] en_vec;
  logic [NSRC-1:0] gclk_vec;
  logic            half_q;
  logic [NSRC-1:0] upd_clk;
  logic [NSRC-1:0] upd_ce;
  logic [NSRC-1:0] src_clk;

  clksel_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .SEL_LSB(SEL_LSB)
  ) u_regs (
    .clk(clk_bus), .rst(rst), .addr(io_addr), .wdata(io_wdata),
    .wr(io_wr), .rd(io_rd), .rdata(io_rdata), .sel(sel)
  );

  clksel_div2 #(.RST_STAGES(SYNC_STAGES)) u_div (
    .clk_fast(clk_fast), .rst_bus(rst), .half_q(half_q)
  );

  clksel_ctrl #(.STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk_bus), .rst(rst), .sel(sel), .en_raw(en_vec),
    .req(req), .src_on(src_on)
  );

  // The halved leg updates on falling fast edges while the halved clock is low.
  assign src_clk = {clk_slow, half_q, clk_fast};
  assign upd_clk = {clk_slow, clk_fast, clk_fast};
  assign upd_ce  = {1'b1, ~half_q, 1'b1};

  for (genvar i = 0; i < NSRC; i++) begin : g_leg
    clksel_leg #(.STAGES(SYNC_STAGES)) u_leg (
      .clk_upd(upd_clk[i]), .upd_ce(upd_ce[i]), .clk_src(src_clk[i]),
      .rst_bus(rst), .req(req[i]), .en(en_vec[i]), .gclk(gclk_vec[i])
    );
  end

  assign cpu_clk = |gclk_vec;

  a_r5_single_enable: assert property (@(posedge clk_bus) disable iff (rst)
    $onehot0(en_vec));
endmodule

// File: tb/cpu_clk_selector_tb.sv
`timescale 1ns/1ps
module cpu_clk_selector_tb;
  logic clk_bus = 0, clk_fast = 0, clk_slow = 0, rst = 1;
  logic [7:0] io_addr = 0, io_wdata = 0, io_rdata;
  logic io_wr = 0, io_rd = 0, cpu_clk;
  logic [2:0] src_on;

  always #5      clk_bus  = ~clk_bus;
  always #25     clk_fast = ~clk_fast;
  always #34.921 clk_slow = ~clk_slow;

  cpu_clk_selector u_dut (
    .clk_bus(clk_bus), .rst(rst), .clk_fast(clk_fast), .clk_slow(clk_slow),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata(io_rdata), .cpu_clk(cpu_clk), .src_on(src_on)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // edge monitor on the output clock
  bit mon_on = 0, mon_seen = 0;
  realtime last_t = 0, min_hi = 1.0e9, min_lo = 1.0e9, max_lo = 0;
  always @(cpu_clk) begin
    if (mon_on) begin
      if (mon_seen) begin
        if (cpu_clk) begin
          if ($realtime - last_t < min_lo) min_lo = $realtime - last_t;
          if ($realtime - last_t > max_lo) max_lo = $realtime - last_t;
        end else if ($realtime - last_t < min_hi) min_hi = $realtime - last_t;
      end
      mon_seen = 1;
    end
    last_t = $realtime;
  end

  function automatic longint ps(input realtime t);
    return longint'($rtoi(t * 1000.0));
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_bus); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk_bus); io_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_bus); io_addr = a; io_rd = 1;
    @(negedge clk_bus); d = io_rdata; io_rd = 0;
  endtask

  task automatic wait_status(input logic [2:0] exp, input string tag);
    int n;
    n = 0;
    while (src_on != exp && n < 3000) begin @(negedge clk_bus); n++; end
    chk(src_on == exp, {tag, " status reached"}, src_on, exp);
  endtask

  task automatic check_period(input longint exp_ps, input string tag);
    realtime t0;
    repeat (3) @(posedge cpu_clk);
    t0 = $realtime;
    @(posedge cpu_clk);
    chk((ps($realtime - t0) - exp_ps) <= 100 && (exp_ps - ps($realtime - t0)) <= 100,
        {tag, " output period ps"}, ps($realtime - t0), exp_ps);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_read(8'h7B, d);
    chk(d == 8'h00, "R1 select cleared", d, 0);
    wait_status(3'b001, "R1");
    check_period(50000, "R1 R4 fast");
  endtask

  task automatic t_other_addr();
    logic [7:0] d;
    bus_write(8'h7A, 8'h0C);
    bus_read(8'h7B, d);
    chk(d == 8'h00, "R3 write elsewhere ignored", d, 0);
    bus_read(8'h7A, d);
    chk(d == 8'h00, "R3 read elsewhere zero", d, 0);
    repeat (40) @(negedge clk_bus);
    chk(src_on == 3'b001, "R3 source unchanged", src_on, 3'b001);
  endtask

  task automatic t_switch(input logic [7:0] wd, input logic [7:0] rb,
                          input logic [2:0] exp, input longint per_ps, input string tag);
    logic [7:0] d;
    logic [2:0] prev;
    bit bad, saw_zero;
    int n;
    max_lo = 0; bad = 0; saw_zero = 0; prev = src_on; n = 0;
    bus_write(8'h7B, wd);
    while (src_on != exp && n < 3000) begin
      @(negedge clk_bus); n++;
      if (src_on != prev) begin
        if (prev != 0 && src_on != 0) bad = 1;
        if (src_on == 0) saw_zero = 1;
        prev = src_on;
      end
    end
    chk(src_on == exp, {tag, " R4 new source active"}, src_on, exp);
    chk(!bad && saw_zero, {tag, " R6 status passes through zero"}, bad, 0);
    check_period(per_ps, {tag, " R4"});
    chk(ps(max_lo) > 55000, {tag, " R6 low gap ps"}, ps(max_lo), 55000);
    bus_read(8'h7B, d);
    chk(d == rb, {tag, " R2 readback"}, d, rb);
  endtask

  task automatic t_same(input logic [7:0] wd, input logic [2:0] exp, input longint lo_ps);
    bit bad;
    bad = 0; max_lo = 0;
    repeat (10) @(posedge cpu_clk);
    max_lo = 0;
    bus_write(8'h7B, wd);
    repeat (200) begin
      @(negedge clk_bus);
      if (src_on != exp) bad = 1;
    end
    chk(!bad, "R8 status held on same-source write", bad, 0);
    chk(ps(max_lo) <= lo_ps + 100, "R8 no stretched low phase ps", ps(max_lo), lo_ps);
    check_period(69842, "R8 R4 code 11 slow");
  endtask

  task automatic t_rapid();
    bit bad;
    bus_write(8'h7B, 8'h04);
    bus_write(8'h7B, 8'h00);
    bus_write(8'h7B, 8'h08);
    wait_status(3'b100, "R9 last code wins");
    bad = 0;
    repeat (300) begin
      @(negedge clk_bus);
      if (src_on != 3'b100) bad = 1;
    end
    chk(!bad, "R9 settled source stays", bad, 0);
    check_period(69842, "R9 R4 slow");
  endtask

  task automatic t_live_reset();
    logic [7:0] d;
    @(negedge clk_bus); rst = 1;
    repeat (30) @(negedge clk_bus);
    rst = 0;
    bus_read(8'h7B, d);
    chk(d == 8'h00, "R1 live reset clears select", d, 0);
    wait_status(3'b001, "R1 live reset");
    check_period(50000, "R1 R4 fast after reset");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (30) @(negedge clk_bus);
    rst = 0;
    repeat (2) @(negedge clk_bus);
    mon_on = 1;
    t_reset();
    t_other_addr();
    t_switch(8'hF4, 8'h04, 3'b010, 100000, "half");
    t_switch(8'h08, 8'h08, 3'b100, 69842, "slow");
    t_same(8'h0C, 3'b100, 34921);
    t_switch(8'h03, 8'h00, 3'b001, 50000, "fast");
    t_rapid();
    t_live_reset();
    chk(ps(min_hi) >= 24990, "R7 shortest high phase ps", ps(min_hi), 25000);
    chk(ps(min_lo) >= 24990, "R7 shortest low phase ps", ps(min_lo), 25000);
    done = 1;
    finish_run();
  end
endmodule